// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address, made of a segment choice and an offset, into a linear address. A small table of descriptors, each holding a base address and a limit, sits in registers and is written through a simple write port. Six segment registers each keep a private copy of the base and limit taken from one table entry. A load names a segment register and a selector; the selector indexes the table, and the chosen entry is copied into that segment register.

Every access names one of the six segment registers and an offset. The offset is compared against the cached limit. If it fits, the block outputs the cached base plus the offset one cycle later. If it does not fit, the block raises a limit fault and marks no address valid. Selector zero is the null selector and cannot be loaded, as can no selector past the end of the table. After reset every segment and every table entry is flat (base zero, full limit), so linear addresses equal offsets until software programs otherwise.

Top module: `seg_xlat`

## Requirements
- R1: During and right after reset, all outputs are 0; every segment register and every table entry holds base 0 and limit 0xFFFF.
- R2: An access whose offset is at most the segment limit gives, on the next cycle, lin_valid=1, lim_fault=0 and lin_addr = (base + offset) modulo 2^24; an offset equal to the limit passes.
- R3: An access whose offset exceeds the segment limit gives, on the next cycle, lim_fault=1, lin_valid=0 and lin_addr=0.
- R4: An access naming segment index 6 or 7 (only 0..5 exist) gives lim_fault=1 and lin_valid=0 on the next cycle.
- R5: A load with a selector from 1 to 7 into segment index 0..5 raises ld_done on the next cycle and from then on that segment translates with the selected entry's base and limit.
- R6: A load with selector 0, a selector of 8 or more, or a segment index of 6 or 7 raises desc_fault (not ld_done) on the next cycle and leaves every segment register unchanged.
- R7: Writing a table entry does not change a segment register that was loaded from it until that register is loaded again; a load in the same cycle as a write to its entry copies the old contents.
- R8: With base 0 and limit 0xFFFF, every offset translates to itself.
- R9: An access in the same cycle as a load into the same segment uses the segment contents from before the load, and both results appear together on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dt_we | input | 1 | Descriptor table write strobe |
| dt_idx | input | 4 | Table entry written (0..7; larger values ignored) |
| dt_base | input | 24 | Base written into the entry |
| dt_limit | input | 16 | Limit (largest legal offset) written into the entry |
| ld_req | input | 1 | Segment register load request |
| ld_seg | input | 3 | Segment register to load |
| ld_sel | input | 4 | Selector indexing the table |
| acc_req | input | 1 | Access request |
| acc_seg | input | 3 | Segment register used by the access |
| acc_ofs | input | 16 | Offset of the access |
| lin_valid | output | 1 | Linear address valid (one cycle after the access) |
| lin_addr | output | 24 | Linear address, zero when not valid |
| lim_fault | output | 1 | Access failed its limit or segment check |
| ld_done | output | 1 | Load completed |
| desc_fault | output | 1 | Load rejected |

## Verification
The assertions take for granted that reset is held for at least one clock before any request and that every input is at a known level at each rising edge, since the previous-cycle comparisons read the inputs of the cycle before. The stimulus drives all inputs only on falling edges, returns every strobe to zero between operations and starts with reset high, so each request is a clean one-cycle pulse with known fields. Same-cycle load, write and access combinations are driven deliberately so the ordering rules are exercised rather than left to chance.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int ADDR_W = 24;
    localparam int OFS_W  = 16;
    localparam int SEL_W  = 4;
    localparam int DESC_N = 8;
    localparam int NSEG   = 6;
    localparam int SEG_W  = $clog2(NSEG);
    localparam int IDX_W  = $clog2(DESC_N);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [OFS_W-1:0]  limit;
    } desc_t;

    function automatic desc_t flat_desc();
        desc_t d;
        d.base  = '0;
        d.limit = '1;
        return d;
    endfunction

    function automatic logic sel_ok(input logic [SEL_W-1:0] sel);
        return (sel != '0) && (32'(sel) < DESC_N);
    endfunction

    function automatic logic seg_ok(input logic [SEG_W-1:0] seg);
        return 32'(seg) < NSEG;
    endfunction

    function automatic logic [ADDR_W-1:0] lin_sum(input logic [ADDR_W-1:0] base,
                                                  input logic [OFS_W-1:0]  ofs);
        return base + {{(ADDR_W-OFS_W){1'b0}}, ofs};
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [SEL_W-1:0] rd_idx,
    output desc_t            rd_desc
);

    desc_t tab_q [DESC_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DESC_N; i++) tab_q[i] <= flat_desc();
        end else if (wr_en && (32'(wr_idx) < DESC_N)) begin
            tab_q[wr_idx[IDX_W-1:0]] <= wr_desc;
        end
    end

    always_comb begin
        if (32'(rd_idx) < DESC_N) rd_desc = tab_q[rd_idx[IDX_W-1:0]];
        else                      rd_desc = flat_desc();
    end

endmodule

// File: rtl/seg_cache.sv
module seg_cache
    import seg_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_req,
    input  logic [SEG_W-1:0] ld_seg,
    input  logic [SEL_W-1:0] ld_sel,
    input  desc_t            tab_desc,
    input  logic [SEG_W-1:0] acc_seg,
    output desc_t            acc_desc,
    output logic             acc_seg_ok,
    output logic             ld_done,
    output logic             desc_fault
);

    desc_t seg_q [NSEG];
    logic  ld_ok;

    assign ld_ok = sel_ok(ld_sel) && seg_ok(ld_seg);

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_done    <= 1'b0;
            desc_fault <= 1'b0;
        end else begin
            ld_done    <= ld_req && ld_ok;
            desc_fault <= ld_req && !ld_ok;
        end
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                seg_q[g] <= flat_desc();
            else if (ld_req && ld_ok && (ld_seg == SEG_W'(g)))
                seg_q[g] <= tab_desc;
        end

        // R6
        seg_keep_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
            desc_fault |-> seg_q[g] == $past(seg_q[g]));

        // R5
        seg_load_copy_chk: assert property (@(posedge clk) disable iff (rst)
            (ld_done && $past(ld_seg) == SEG_W'(g)) |-> seg_q[g] == $past(tab_desc));
    end

    assign acc_seg_ok = seg_ok(acc_seg);
    assign acc_desc   = acc_seg_ok ? seg_q[acc_seg] : flat_desc();

    // R5
    ld_result_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_done && desc_fault));

    // R6
    ld_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_done || desc_fault) |-> $past(ld_req));

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_req,
    input  logic              acc_seg_ok,
    input  desc_t             seg_desc,
    input  logic [OFS_W-1:0]  acc_ofs,
    output logic              lin_valid,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              lim_fault
);

    logic in_lim;

    assign in_lim = acc_seg_ok && (acc_ofs <= seg_desc.limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            lin_valid <= 1'b0;
            lim_fault <= 1'b0;
            lin_addr  <= '0;
        end else begin
            lin_valid <= acc_req && in_lim;
            lim_fault <= acc_req && !in_lim;
            lin_addr  <= (acc_req && in_lim) ? lin_sum(seg_desc.base, acc_ofs) : '0;
        end
    end

    // R3
    valid_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lin_valid && lim_fault));

    // R3
    fault_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        lim_fault |-> lin_addr == '0);

    // R2
    result_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (lin_valid || lim_fault) |-> $past(acc_req));

    // R8
    flat_identity_chk: assert property (@(posedge clk) disable iff (rst)
        (lin_valid && $past(seg_desc.base) == '0)
            |-> lin_addr == {{(ADDR_W-OFS_W){1'b0}}, $past(acc_ofs)});

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dt_we,
    input  logic [SEL_W-1:0]  dt_idx,
    input  logic [ADDR_W-1:0] dt_base,
    input  logic [OFS_W-1:0]  dt_limit,
    input  logic              ld_req,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic              acc_req,
    input  logic [SEG_W-1:0]  acc_seg,
    input  logic [OFS_W-1:0]  acc_ofs,
    output logic              lin_valid,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              lim_fault,
    output logic              ld_done,
    output logic              desc_fault
);

    desc_t wr_desc;
    desc_t tab_desc;
    desc_t acc_desc;
    logic  acc_seg_ok;

    assign wr_desc.base  = dt_base;
    assign wr_desc.limit = dt_limit;

    seg_desc_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dt_we),
        .wr_idx  (dt_idx),
        .wr_desc (wr_desc),
        .rd_idx  (ld_sel),
        .rd_desc (tab_desc)
    );

    seg_cache u_cache (
        .clk        (clk),
        .rst        (rst),
        .ld_req     (ld_req),
        .ld_seg     (ld_seg),
        .ld_sel     (ld_sel),
        .tab_desc   (tab_desc),
        .acc_seg    (acc_seg),
        .acc_desc   (acc_desc),
        .acc_seg_ok (acc_seg_ok),
        .ld_done    (ld_done),
        .desc_fault (desc_fault)
    );

    seg_xlat_unit u_xlat (
        .clk        (clk),
        .rst        (rst),
        .acc_req    (acc_req),
        .acc_seg_ok (acc_seg_ok),
        .seg_desc   (acc_desc),
        .acc_ofs    (acc_ofs),
        .lin_valid  (lin_valid),
        .lin_addr   (lin_addr),
        .lim_fault  (lim_fault)
    );

    // R4
    bad_seg_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !seg_ok(acc_seg)) |=> (lim_fault && !lin_valid));

endmodule

// File: tb/seg_xlat_test.sv
module seg_xlat_test;
    import seg_xlat_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dt_we = 1'b0;
    logic [SEL_W-1:0]  dt_idx = '0;
    logic [ADDR_W-1:0] dt_base = '0;
    logic [OFS_W-1:0]  dt_limit = '0;
    logic              ld_req = 1'b0;
    logic [SEG_W-1:0]  ld_seg = '0;
    logic [SEL_W-1:0]  ld_sel = '0;
    logic              acc_req = 1'b0;
    logic [SEG_W-1:0]  acc_seg = '0;
    logic [OFS_W-1:0]  acc_ofs = '0;
    logic              lin_valid, lim_fault, ld_done, desc_fault;
    logic [ADDR_W-1:0] lin_addr;

    always #10 clk = ~clk;

    seg_xlat uut (.*);

    typedef struct {
        logic              lv;
        logic [ADDR_W-1:0] la;
        logic              lf;
        logic              ld;
        logic              df;
        int                due;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    logic [ADDR_W-1:0] mb [DESC_N];
    logic [OFS_W-1:0]  ml [DESC_N];
    logic [ADDR_W-1:0] sb [NSEG];
    logic [OFS_W-1:0]  sl [NSEG];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (lin_valid !== e.lv || lin_addr !== e.la || lim_fault !== e.lf ||
                    ld_done !== e.ld || desc_fault !== e.df) begin
                    bad++;
                    $display("FAIL %s: got v=%0b a=%h f=%0b ld=%0b df=%0b exp v=%0b a=%h f=%0b ld=%0b df=%0b",
                             e.tag, lin_valid, lin_addr, lim_fault, ld_done, desc_fault,
                             e.lv, e.la, e.lf, e.ld, e.df);
                end
            end else if (lin_valid || lim_fault || ld_done || desc_fault || lin_addr != '0) begin
                total++;
                bad++;
                $display("FAIL R2 idle output: got v=%0b a=%h f=%0b ld=%0b df=%0b exp all zero",
                         lin_valid, lin_addr, lim_fault, ld_done, desc_fault);
            end
        end
    end

    task automatic op(input bit we, input int widx, input logic [ADDR_W-1:0] wb,
                      input logic [OFS_W-1:0] wl, input bit ld, input int lseg, input int lsel,
                      input bit ac, input int aseg, input logic [OFS_W-1:0] ofs,
                      input string tag);
        exp_t e;
        @(negedge clk);
        dt_we = we; dt_idx = SEL_W'(widx); dt_base = wb; dt_limit = wl;
        ld_req = ld; ld_seg = SEG_W'(lseg); ld_sel = SEL_W'(lsel);
        acc_req = ac; acc_seg = SEG_W'(aseg); acc_ofs = ofs;
        e.lv = 0; e.la = '0; e.lf = 0; e.ld = 0; e.df = 0; e.due = cyc + 1; e.tag = tag;
        if (ac) begin
            if (aseg < NSEG && ofs <= sl[aseg]) begin
                e.lv = 1;
                e.la = sb[aseg] + ADDR_W'(ofs);
            end else e.lf = 1;
        end
        if (ld) begin
            if (lsel != 0 && lsel < DESC_N && lseg < NSEG) begin
                e.ld = 1;
                sb[lseg] = mb[lsel];
                sl[lseg] = ml[lsel];
            end else e.df = 1;
        end
        if (we && widx < DESC_N) begin
            mb[widx] = wb;
            ml[widx] = wl;
        end
        if (ac || ld) q.push_back(e);
        @(negedge clk);
        dt_we = 0; ld_req = 0; acc_req = 0;
    endtask

    task automatic acc(input int seg, input logic [OFS_W-1:0] ofs, input string tag);
        op(0, 0, '0, '0, 0, 0, 0, 1, seg, ofs, tag);
    endtask

    task automatic load(input int seg, input int sel, input string tag);
        op(0, 0, '0, '0, 1, seg, sel, 0, 0, '0, tag);
    endtask

    task automatic wr(input int idx, input logic [ADDR_W-1:0] b, input logic [OFS_W-1:0] l);
        op(1, idx, b, l, 0, 0, 0, 0, 0, '0, "wr");
    endtask

    initial begin
        for (int i = 0; i < DESC_N; i++) begin mb[i] = '0; ml[i] = '1; end
        for (int i = 0; i < NSEG; i++) begin sb[i] = '0; sl[i] = '1; end
        repeat (3) @(negedge clk);
        // R1 outputs held low in reset
        total++;
        if (lin_valid || lim_fault || ld_done || desc_fault || lin_addr != '0) begin
            bad++;
            $display("FAIL R1 reset outputs: got v=%0b a=%h f=%0b ld=%0b df=%0b exp all zero",
                     lin_valid, lin_addr, lim_fault, ld_done, desc_fault);
        end
        rst = 0;
        // R1 / R8: flat after reset
        for (int s = 0; s < NSEG; s++) acc(s, 16'h1234 + 16'(s), "R1 R8 flat");
        acc(0, 16'hFFFF, "R8 max offset");
        acc(5, 16'h0000, "R8 zero offset");
        // R1: every table entry starts flat
        load(4, 3, "R1 table reset load");
        acc(4, 16'hFFFF, "R1 table entry flat");
        // program table
        wr(1, 24'h100000, 16'h0FFF);
        wr(2, 24'hFFFF00, 16'hFFFF);
        wr(7, 24'h00AB00, 16'h0000);
        wr(9, 24'h123456, 16'h0001);
        // R5 / R2 / R3
        load(1, 1, "R5 load seg1");
        acc(1, 16'h0FFF, "R2 limit boundary");
        acc(1, 16'h1000, "R3 over limit");
        acc(1, 16'h0000, "R2 zero offset");
        load(2, 2, "R5 load seg2");
        acc(2, 16'h0200, "R2 wrap");
        load(5, 7, "R5 load seg5");
        acc(5, 16'h0000, "R2 zero limit");
        acc(5, 16'h0001, "R3 zero limit over");
        // R6
        load(3, 0, "R6 null selector");
        load(3, 8, "R6 selector past table");
        load(3, 15, "R6 selector max");
        load(6, 1, "R6 segment 6");
        load(7, 2, "R6 segment 7");
        acc(3, 16'hFFFF, "R6 seg3 unchanged");
        acc(1, 16'h0FFF, "R6 seg1 unchanged");
        // R4
        acc(6, 16'h0000, "R4 segment 6");
        acc(7, 16'h0010, "R4 segment 7");
        // R7
        wr(1, 24'h200000, 16'h00FF);
        acc(1, 16'h0800, "R7 stale cache kept");
        load(0, 1, "R7 reload seg0");
        acc(0, 16'h0800, "R7 new limit");
        acc(0, 16'h0010, "R7 new base");
        op(1, 2, 24'h333333, 16'h0001, 1, 4, 2, 0, 0, '0, "R7 write with load");
        acc(4, 16'h0100, "R7 load got old entry");
        // R9
        op(0, 0, '0, '0, 1, 1, 7, 1, 1, 16'h0080, "R9 load with access");
        acc(1, 16'h0000, "R9 after load");
        acc(1, 16'h0001, "R9 after load limit");
        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R2 missing results: got %0d pending exp 0", q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule